// File: doc/BRIEF.md
# Eight-Channel Output-Compare Timer with Broadcast Channel

This block is an eight-channel, 16-bit output-compare timer driven by a single free-running counter. A prescaler divides the input clock by a power of two before the counter. Each channel holds a compare value, a bit that arms it for output compare, a two-bit pin action, a sticky event flag and an interrupt enable. When the counter arrives at a channel's compare value, the channel raises its flag and applies its action to its own pin.

The highest channel also serves as a broadcast source. At its compare event it loads every pin selected by a group mask with the matching bit of a group data register. Software can use this to start several outputs on the same clock edge and then end them one by one with the other channels' own actions. A pin that the timer controls replaces the general-purpose port bit on that output. A synchronous single-cycle register bus with a combinational read path gives access. Flags are cleared by writing ones. A read-modify-write of the flag register therefore clears every flag that is pending.

Register map (5-bit word address, 16-bit data): 0x00 control (bit 0 run, bits 3:1 prescale select), 0x01 compare-arm bits, 0x02 pin actions (channel n in bits 2n+1:2n), 0x03 flags, 0x04 interrupt enables, 0x05 group mask, 0x06 group data, 0x07 port data, 0x08 counter (read only), 0x10+n compare value of channel n.

Top module: `oc_timer`

## Requirements
- R1: The counter stays fixed while the run bit (control bit 0) is 0. While the run bit is 1 it advances by one on each prescaler tick, wraps from 0xFFFF to 0x0000 and reads back at address 0x08. It resets to 0.
- R2: With prescale select s (control bits 3:1), a tick occurs once every 2^s clock cycles, so the counter advances exactly 10 in any 80-cycle window when s = 3.
- R3: Channel n raises an event only when its arm bit (bit n of 0x01) is 1 and the counter steps onto the value at 0x10+n. The flag is set on that same edge. A compare value written while the counter already holds it, and no step happens, raises no event.
- R4: On its own event, a channel applies its action field to its pin latch: 00 leaves it, 01 inverts it, 10 drives 0, 11 drives 1. With no event, no pin latch changes.
- R5: On a channel 7 event, every pin whose group mask bit (0x05) is 1 takes the matching bit of the group data register (0x06).
- R6: When channel 7 and another channel have events in the same cycle, a masked pin takes the group data bit and ignores its own action. An unmasked pin still applies its own action.
- R7: Pin n outputs its timer latch when its group mask bit is 1, or when its arm bit is 1 and its action is not 00. Otherwise it outputs bit n of the port register (0x07).
- R8: Reading 0x03 returns the flags. A write to 0x03 clears every flag written as 1 and leaves flags written as 0 unchanged. An event in the same cycle as its clear leaves the flag set.
- R9: The interrupt output is high exactly when some flag and its enable bit (0x04) are both 1.
- R10: After reset all registers, flags, pin latches, the counter and the interrupt output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous-style reset, sampled on clk |
| bus_wr | input | 1 | Write strobe; the write takes effect on the rising edge |
| bus_addr | input | 5 | Word address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pin_out | output | 8 | Channel output pins |
| irq | output | 1 | Interrupt request |

## Verification
Two collisions matter in this block. The first is channel 7's group broadcast landing on the same edge as another channel's own action. The bench sets channels 0, 1 and 7 to one compare value, with only pin 0 masked and both channel 0 and channel 1 set to drive high. Pin 0 must follow the group data bit (0) and pin 1 its own action (1). The second is a flag being set and cleared together. The bench stops the counter, places a compare value one step ahead and restarts with divide-by-two, so that the arriving event and a write-one-to-clear of the same flag fall on the same edge. The flag must read back as set.

// File: rtl/oc_pkg.sv
package oc_pkg;

    localparam int ADDR_W = 5;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } pin_act_e;

    localparam logic [ADDR_W-1:0] A_CTRL   = 5'h00;
    localparam logic [ADDR_W-1:0] A_ARM    = 5'h01;
    localparam logic [ADDR_W-1:0] A_ACTION = 5'h02;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 5'h03;
    localparam logic [ADDR_W-1:0] A_IEN    = 5'h04;
    localparam logic [ADDR_W-1:0] A_GMASK  = 5'h05;
    localparam logic [ADDR_W-1:0] A_GDATA  = 5'h06;
    localparam logic [ADDR_W-1:0] A_PORT   = 5'h07;
    localparam logic [ADDR_W-1:0] A_COUNT  = 5'h08;
    localparam logic [ADDR_W-1:0] A_CMP0   = 5'h10;

endpackage

// File: rtl/oc_prescale.sv
module oc_prescale #(
    parameter int PSW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [PSW-1:0] sel,
    output logic           tick
);
    localparam int DIVW = (1 << PSW) - 1;

    logic [DIVW-1:0] div_d, div_q;
    logic [DIVW-1:0] mask;

    always_comb begin
        mask  = ~({DIVW{1'b1}} << sel);
        tick  = run && ((div_q & mask) == mask);
        div_d = run ? div_q + 1'b1 : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/oc_match.sv
module oc_match #(
    parameter int NCH = 8,
    parameter int CW  = 16
) (
    input  logic                     tick,
    input  logic [CW-1:0]            cnt_next,
    input  logic [NCH-1:0]           arm,
    input  logic [NCH-1:0][CW-1:0]   cmp,
    output logic [NCH-1:0]           ev
);
    // Compare against the value the counter is about to take, so the
    // event is registered on the same edge as the counter step.
    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        assign ev[g] = tick && arm[g] && (cmp[g] == cnt_next);
    end
endmodule

// File: rtl/oc_pinlogic.sv
module oc_pinlogic
    import oc_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic [NCH-1:0]        ev,
    input  logic [NCH-1:0][1:0]   act,
    input  logic [NCH-1:0]        arm,
    input  logic [NCH-1:0]        gmask,
    input  logic [NCH-1:0]        gdata,
    input  logic [NCH-1:0]        port,
    input  logic [NCH-1:0]        pin_q,
    output logic [NCH-1:0]        pin_d,
    output logic [NCH-1:0]        pin_out
);
    localparam int MST = NCH - 1;

    for (genvar g = 0; g < NCH; g++) begin : g_pin
        logic nxt;
        logic ctl;

        always_comb begin
            nxt = pin_q[g];
            if (ev[g]) begin
                case (pin_act_e'(act[g]))
                    ACT_TOGGLE: nxt = ~pin_q[g];
                    ACT_CLEAR:  nxt = 1'b0;
                    ACT_SET:    nxt = 1'b1;
                    default:    nxt = pin_q[g];
                endcase
            end
            // group broadcast has the last word on a masked pin
            if (ev[MST] && gmask[g]) nxt = gdata[g];
        end

        assign ctl        = gmask[g] || (arm[g] && (pin_act_e'(act[g]) != ACT_NONE));
        assign pin_d[g]   = nxt;
        assign pin_out[g] = ctl ? pin_q[g] : port[g];
    end
endmodule

// File: rtl/oc_timer.sv
module oc_timer
    import oc_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 16,
    parameter int DW  = 16,
    parameter int PSW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [NCH-1:0]    pin_out,
    output logic              irq
);
    localparam int CIW = $clog2(NCH);

    typedef struct packed {
        logic                   run;
        logic [PSW-1:0]         psel;
        logic [NCH-1:0]         arm;
        logic [NCH-1:0][1:0]    act;
        logic [NCH-1:0]         flags;
        logic [NCH-1:0]         ien;
        logic [NCH-1:0]         gmask;
        logic [NCH-1:0]         gdata;
        logic [NCH-1:0]         port;
        logic [NCH-1:0]         pin;
        logic [CW-1:0]          cnt;
        logic [NCH-1:0][CW-1:0] cmp;
    } regs_t;

    regs_t r_d, r_q;

    logic            tick;
    logic [CW-1:0]   cnt_next;
    logic [NCH-1:0]  ev;
    logic [NCH-1:0]  pin_d;
    logic [NCH-1:0]  clr;
    logic            cmp_hit;
    logic [CIW-1:0]  cmp_idx;

    // signals handed to the bound checker
    logic [CW-1:0]   chk_cnt;
    logic [NCH-1:0]  chk_flags;
    logic [NCH-1:0]  chk_pin;
    logic [NCH-1:0]  chk_gmask;
    logic [NCH-1:0]  chk_gdata;
    logic            chk_run;

    oc_prescale #(.PSW(PSW)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.run),
        .sel   (r_q.psel),
        .tick  (tick)
    );

    oc_match #(.NCH(NCH), .CW(CW)) u_match (
        .tick     (tick),
        .cnt_next (cnt_next),
        .arm      (r_q.arm),
        .cmp      (r_q.cmp),
        .ev       (ev)
    );

    oc_pinlogic #(.NCH(NCH)) u_pins (
        .ev      (ev),
        .act     (r_q.act),
        .arm     (r_q.arm),
        .gmask   (r_q.gmask),
        .gdata   (r_q.gdata),
        .port    (r_q.port),
        .pin_q   (r_q.pin),
        .pin_d   (pin_d),
        .pin_out (pin_out)
    );

    assign cnt_next = r_q.cnt + 1'b1;
    assign cmp_hit  = (int'(bus_addr) >= int'(A_CMP0)) &&
                      (int'(bus_addr) <  int'(A_CMP0) + NCH);
    assign cmp_idx  = CIW'(int'(bus_addr) - int'(A_CMP0));

    always_comb begin
        r_d = r_q;
        clr = '0;

        if (tick) r_d.cnt = cnt_next;

        if (bus_wr) begin
            case (bus_addr)
                A_CTRL: begin
                    r_d.run  = bus_wdata[0];
                    r_d.psel = bus_wdata[PSW:1];
                end
                A_ARM:    r_d.arm   = bus_wdata[NCH-1:0];
                A_ACTION: r_d.act   = bus_wdata[2*NCH-1:0];
                A_FLAGS:  clr       = bus_wdata[NCH-1:0];
                A_IEN:    r_d.ien   = bus_wdata[NCH-1:0];
                A_GMASK:  r_d.gmask = bus_wdata[NCH-1:0];
                A_GDATA:  r_d.gdata = bus_wdata[NCH-1:0];
                A_PORT:   r_d.port  = bus_wdata[NCH-1:0];
                default: begin
                    if (cmp_hit) r_d.cmp[cmp_idx] = bus_wdata[CW-1:0];
                end
            endcase
        end

        // an arriving event outranks a clear in the same cycle
        r_d.flags = (r_q.flags & ~clr) | ev;
        r_d.pin   = pin_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:   bus_rdata = DW'({r_q.psel, r_q.run});
            A_ARM:    bus_rdata = DW'(r_q.arm);
            A_ACTION: bus_rdata = DW'(r_q.act);
            A_FLAGS:  bus_rdata = DW'(r_q.flags);
            A_IEN:    bus_rdata = DW'(r_q.ien);
            A_GMASK:  bus_rdata = DW'(r_q.gmask);
            A_GDATA:  bus_rdata = DW'(r_q.gdata);
            A_PORT:   bus_rdata = DW'(r_q.port);
            A_COUNT:  bus_rdata = DW'(r_q.cnt);
            default: begin
                if (cmp_hit) bus_rdata = DW'(r_q.cmp[cmp_idx]);
            end
        endcase
    end

    assign irq = |(r_q.flags & r_q.ien);

    assign chk_cnt   = r_q.cnt;
    assign chk_flags = r_q.flags;
    assign chk_pin   = r_q.pin;
    assign chk_gmask = r_q.gmask;
    assign chk_gdata = r_q.gdata;
    assign chk_run   = r_q.run;
endmodule

// File: rtl/oc_timer_chk.sv
module oc_timer_chk
    import oc_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NCH-1:0]    wlow,
    input logic              run,
    input logic [CW-1:0]     cnt,
    input logic [NCH-1:0]    ev,
    input logic [NCH-1:0]    flags,
    input logic [NCH-1:0]    pin,
    input logic [NCH-1:0]    gmask,
    input logic [NCH-1:0]    gdata,
    input logic              irq
);
    logic [NCH-1:0] keep;
    assign keep = flags & ~((bus_wr && bus_addr == A_FLAGS) ? wlow : '0);

    p_hold_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt));

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (cnt == $past(cnt) || cnt == CW'($past(cnt) + 1'b1)));

    p_flag_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flags) |-> ((flags & ~$past(flags) & ~$past(ev)) == '0));

    p_pin_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == '0) |=> $stable(pin));

    // R5 and R6: masked pins follow group data on a channel 7 event
    p_group_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev[NCH-1] |=> ((pin & $past(gmask)) == ($past(gdata) & $past(gmask))));

    p_keep_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (keep != '0) |=> ((flags & $past(keep)) == $past(keep)));

    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |-> !irq);
endmodule

bind oc_timer oc_timer_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wlow     (bus_wdata[NCH-1:0]),
    .run      (chk_run),
    .cnt      (chk_cnt),
    .ev       (ev),
    .flags    (chk_flags),
    .pin      (chk_pin),
    .gmask    (chk_gmask),
    .gdata    (chk_gdata),
    .irq      (irq)
);

// File: tb/tb_oc_timer.sv
module tb_oc_timer;
    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] R_CTRL = 5'h00, R_ARM = 5'h01, R_ACT = 5'h02,
                           R_FLG = 5'h03, R_IEN = 5'h04, R_GMK = 5'h05,
                           R_GDT = 5'h06, R_PRT = 5'h07, R_CNT = 5'h08,
                           R_CMP = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  pin_out;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    oc_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // vector: {channel[2:0], action[1:0], port bit, expected pin}
    localparam logic [6:0] VEC [8] = '{
        {3'd0, 2'b11, 1'b0, 1'b1},
        {3'd0, 2'b01, 1'b1, 1'b0},
        {3'd0, 2'b01, 1'b0, 1'b1},
        {3'd0, 2'b10, 1'b1, 1'b0},
        {3'd0, 2'b00, 1'b1, 1'b1},
        {3'd0, 2'b00, 1'b0, 1'b0},
        {3'd2, 2'b11, 1'b0, 1'b1},
        {3'd2, 2'b01, 1'b1, 1'b0}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_flag(input int ch, input int limit, output bit seen);
        logic [15:0] f;
        seen = 1'b0;
        for (int i = 0; i < limit && !seen; i++) begin
            bus_read(R_FLG, f);
            if (f[ch]) seen = 1'b1;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got 0x1 expected 0x0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [15:0] d, c, c2;
        bit seen;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        #1;
        check(pin_out == 8'h00, "R10 pins after reset", pin_out, 8'h00);
        check(irq == 1'b0, "R10 irq after reset", irq, 0);
        bus_read(R_FLG, d);
        check(d == 16'h0, "R10 flags after reset", d, 0);
        bus_read(R_CNT, c);
        repeat (5) @(negedge clk);
        bus_read(R_CNT, c2);
        check(c == 16'h0 && c2 == 16'h0, "R1 counter idle while stopped", c2, 0);

        bus_write(R_CTRL, 16'h0001);

        // R4 / R7: action table on channel pins
        foreach (VEC[i]) begin
            logic [2:0] ch;
            ch = VEC[i][6:4];
            bus_write(R_PRT, 16'(VEC[i][1]) << ch);
            bus_write(R_ACT, 16'(VEC[i][3:2]) << (2 * ch));
            bus_write(R_ARM, 16'h1 << ch);
            bus_write(R_FLG, 16'h00FF);
            bus_read(R_CNT, c);
            bus_write(R_CMP + 5'(ch), c + 16'd30);
            wait_flag(int'(ch), 80, seen);
            check(seen, "R3 event flag from table", 32'(seen), 1);
            check(pin_out[ch] == VEC[i][0], "R4 R7 pin after action", pin_out[ch], VEC[i][0]);
        end

        // R3: disarmed channel never fires
        bus_write(R_ARM, 16'h0000);
        bus_write(R_FLG, 16'h00FF);
        bus_read(R_CNT, c);
        bus_write(R_CMP, c + 16'd20);
        repeat (60) @(negedge clk);
        bus_read(R_FLG, d);
        check(d == 16'h0, "R3 disarmed channel", d, 0);

        // R2: divide by 8 gives 10 steps in 80 cycles
        bus_write(R_CTRL, 16'h0007);
        bus_read(R_CNT, c);
        repeat (79) @(negedge clk);
        bus_read(R_CNT, c2);
        check(16'(c2 - c) == 16'd10, "R2 prescale by 8", 16'(c2 - c), 10);
        bus_write(R_CTRL, 16'h0001);

        // R8 / R9: write-one-to-clear and interrupt
        bus_write(R_ACT, 16'h0000);
        bus_write(R_ARM, 16'h0003);
        bus_write(R_FLG, 16'h00FF);
        bus_read(R_CNT, c);
        bus_write(R_CMP + 5'd0, c + 16'd20);
        bus_write(R_CMP + 5'd1, c + 16'd25);
        repeat (40) @(negedge clk);
        bus_read(R_FLG, d);
        check(d == 16'h0003, "R8 two flags pending", d, 3);
        #1 check(irq == 1'b0, "R9 irq with no enables", irq, 0);
        bus_write(R_IEN, 16'h0002);
        #1 check(irq == 1'b1, "R9 irq with enabled flag", irq, 1);
        bus_write(R_FLG, 16'h0001);
        bus_read(R_FLG, d);
        check(d == 16'h0002, "R8 clear one flag", d, 2);
        bus_write(R_FLG, 16'h0000);
        bus_read(R_FLG, d);
        check(d == 16'h0002, "R8 write zero keeps flags", d, 2);
        bus_write(R_IEN, 16'h0001);
        #1 check(irq == 1'b0, "R9 irq with other enable", irq, 0);
        bus_read(R_FLG, d);
        bus_write(R_FLG, d);
        bus_read(R_FLG, d);
        check(d == 16'h0000, "R8 read-modify-write clears all", d, 0);
        bus_write(R_IEN, 16'h0000);

        // R8: event and clear on the same edge, flag stays set
        bus_write(R_CTRL, 16'h0000);
        bus_write(R_ARM, 16'h0001);
        bus_read(R_CNT, c);
        bus_write(R_CMP, c + 16'd1);
        bus_write(R_FLG, 16'h00FF);
        bus_write(R_CTRL, 16'h0003);
        bus_write(R_FLG, 16'h0001);
        bus_read(R_FLG, d);
        check(d[0] == 1'b1, "R8 set beats clear", d[0], 1);
        bus_write(R_CTRL, 16'h0001);

        // R5 / R7: group broadcast
        bus_write(R_ARM, 16'h0080);
        bus_write(R_ACT, 16'h0000);
        bus_write(R_PRT, 16'h00A0);
        bus_write(R_GDT, 16'h0005);
        bus_write(R_GMK, 16'h000F);
        bus_write(R_FLG, 16'h00FF);
        bus_read(R_CNT, c);
        bus_write(R_CMP + 5'd7, c + 16'd20);
        wait_flag(7, 80, seen);
        check(seen, "R5 channel 7 flag", 32'(seen), 1);
        check(pin_out == 8'hA5, "R5 group pattern on pins", pin_out, 8'hA5);

        // R6: same-cycle collision, group data wins on masked pin
        bus_write(R_GMK, 16'h0001);
        bus_write(R_GDT, 16'h0000);
        bus_write(R_PRT, 16'h0000);
        bus_write(R_ACT, 16'h000F);
        bus_write(R_ARM, 16'h0083);
        bus_write(R_FLG, 16'h00FF);
        bus_read(R_CNT, c);
        bus_write(R_CMP + 5'd0, c + 16'd30);
        bus_write(R_CMP + 5'd1, c + 16'd30);
        bus_write(R_CMP + 5'd7, c + 16'd30);
        wait_flag(7, 80, seen);
        bus_read(R_FLG, d);
        check(d[7:0] == 8'h83, "R6 three flags together", d[7:0], 8'h83);
        check(pin_out == 8'h02, "R6 group beats own action", pin_out, 8'h02);

        // R3: compare written to the held count does not fire
        bus_write(R_CTRL, 16'h0000);
        bus_write(R_ARM, 16'h0001);
        bus_write(R_FLG, 16'h00FF);
        bus_read(R_CNT, c);
        bus_write(R_CMP, c);
        repeat (10) @(negedge clk);
        bus_read(R_FLG, d);
        check(d[0] == 1'b0, "R3 no fire on held equal count", d[0], 0);

        // R1: counter wraps to zero
        bus_write(R_CMP, 16'h0000);
        bus_write(R_CTRL, 16'h0001);
        wait_flag(0, 70000, seen);
        check(seen, "R1 wrap reaches zero", 32'(seen), 1);
        bus_read(R_CNT, c);
        check(c < 16'd16, "R1 count small after wrap", c, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule